// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept. It looks at the first six bytes of the frame, which hold the 48-bit destination address. The receive path streams these bytes into the block one per cycle. One cycle after the sixth byte, the block gives an accept verdict and two status flags for the receive descriptor. When the frame's last byte arrives, it also gives a final frame-level verdict that adds a minimum-length check.

The filter keeps a table of sixteen exact-match addresses. Software loads the table by streaming a setup buffer through a separate byte port. The buffer takes effect only when it is exactly 192 bytes long. Each address sits in a 12-byte group in which only some byte slots carry data. Four mode inputs are applied in a fixed priority:

- The all-ones broadcast address is always accepted.
- Promiscuous or receive-all mode comes next.
- Pass-all-multicast comes after that.
- Inverse filtering applies last and flips the exact-match result.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, every output is 0 and all sixteen table entries hold the all-zero address. A nonzero unicast address is then rejected when no mode is set, and the all-zero address matches.
- R2: Destination bytes are taken in arrival order as address bytes 0..5. `decValid` pulses for exactly one cycle, in the cycle right after the sixth byte of a frame is sampled. It is 0 in the cycle after the fifth byte.
- R3: A setup buffer, from its first byte through the byte marked by `setupLast`, loads the table only if it is exactly 192 bytes long. A buffer of 191 or 193 bytes leaves every entry unchanged.
- R4: Entry n is taken from buffer offsets 12n+0, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9, which become address bytes 0 to 5 in that order. The other offsets are ignored.
- R5: The all-ones address is accepted with both flags at 0, whatever the mode inputs are, including inverse filtering.
- R6: Otherwise, when `modePromisc` or `modeRecvAll` is 1, the frame is accepted with `flagFiltFail`=1 and `flagMcast`=0.
- R7: Otherwise, when `modePassMcast` is 1 and bit 0 of address byte 0 is 1, the frame is accepted with `flagMcast`=1 and `flagFiltFail`=0.
- R8: Otherwise, `addrAccept` is the result of an exact match against any table entry, inverted when `modeInverse` is 1. Both flags are 0.
- R9: `frameDone` pulses in the cycle after the byte marked by `rxLast`. `frameAccept` equals the address verdict when the frame has at least 14 bytes, and is 0 for shorter frames, including frames shorter than six bytes.
- R10: All sixteen entries take part in matching at the same time, so an address equal to any one of them is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modePromisc | input | 1 | Promiscuous mode |
| modeRecvAll | input | 1 | Receive-all mode |
| modePassMcast | input | 1 | Pass all multicast addresses |
| modeInverse | input | 1 | Invert the exact-match result |
| setupValid | input | 1 | Setup buffer byte valid |
| setupByte | input | 8 | Setup buffer byte |
| setupLast | input | 1 | Marks the last byte of a setup buffer |
| rxValid | input | 1 | Frame byte valid |
| rxByte | input | 8 | Frame byte |
| rxLast | input | 1 | Marks the last byte of a frame |
| decValid | output | 1 | One-cycle pulse: the address verdict is new |
| addrAccept | output | 1 | Address verdict, held until the next one |
| flagFiltFail | output | 1 | Accepted only because of promiscuous or receive-all mode |
| flagMcast | output | 1 | Accepted because of pass-all-multicast |
| frameDone | output | 1 | One-cycle pulse after a frame's last byte |
| frameAccept | output | 1 | Frame verdict, valid with `frameDone` |

## Verification
Suppose the setup counters lose their place, for example by wrapping at the wrong offset, or by committing a buffer of the wrong length. Then a table entry holds wrong or mixed bytes. This shows up on the very next frame aimed at that entry, as a rejection in its `decValid` cycle. A stale frame byte counter shows up in a different way: `decValid` moves off the cycle after the sixth byte, or `frameAccept` goes wrong for frames of 13 or 14 bytes. The bench therefore matches every entry after each load. It sweeps all sixteen mode combinations against four address classes, and it probes lengths on both sides of each limit.

// File: rtl/daf_pkg.sv
package daf_pkg;
  parameter int ENTRIES     = 16;
  parameter int ADDR_BYTES  = 6;
  parameter int GROUP_BYTES = 2 * ADDR_BYTES;
  parameter int SETUP_LEN   = ENTRIES * GROUP_BYTES;
  parameter int MIN_FRAME   = 14;
  parameter int ENT_W       = $clog2(ENTRIES);
  parameter int GRP_W       = ENT_W + 1;
  parameter int OFF_W       = $clog2(GROUP_BYTES);
  parameter int BYTE_W      = $clog2(ADDR_BYTES);
  parameter int CNT_W       = $clog2(MIN_FRAME) + 1;

  typedef logic [ADDR_BYTES-1:0][7:0] mac_t;

  typedef struct packed {
    logic              stageWr;
    logic [ENT_W-1:0]  stageEnt;
    logic [BYTE_W-1:0] stageByte;
    logic              commit;
    logic              addrWr;
    logic [BYTE_W-1:0] addrIdx;
    logic              decide;
    logic              frameEnd;
    logic              lenOk;
  } daf_strobe_t;
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        setupValid,
  input  logic        setupLast,
  input  logic        rxValid,
  input  logic        rxLast,
  output daf_strobe_t strb
);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(GROUP_BYTES - 1);
  localparam logic [GRP_W-1:0] GRP_OVER  = GRP_W'(ENTRIES);
  localparam logic [GRP_W-1:0] GRP_LAST  = GRP_W'(ENTRIES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] ADDR_N    = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] LEN_LAST  = CNT_W'(MIN_FRAME - 1);

  logic [OFF_W-1:0] setOff;   // byte offset inside the current 12-byte group
  logic [GRP_W-1:0] setGrp;   // group index; ENTRIES means the buffer ran too long
  logic [CNT_W-1:0] rxCnt;    // bytes seen so far in the current frame, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setOff <= '0;
      setGrp <= '0;
    end else if (setupValid) begin
      if (setupLast) begin
        setOff <= '0;
        setGrp <= '0;
      end else if (setOff == OFF_LAST) begin
        setOff <= '0;
        if (setGrp != GRP_OVER) setGrp <= setGrp + 1'b1;
      end else begin
        setOff <= setOff + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxCnt <= '0;
    end else if (rxValid) begin
      if (rxLast)                rxCnt <= '0;
      else if (rxCnt != CNT_MAX) rxCnt <= rxCnt + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    // used slots have offset bit 1 clear: 0,1,4,5,8,9
    strb.stageWr   = setupValid && (setGrp < GRP_OVER) && !setOff[1];
    strb.stageEnt  = setGrp[ENT_W-1:0];
    strb.stageByte = BYTE_W'({setOff[OFF_W-1:2], setOff[0]});
    strb.commit    = setupValid && setupLast && (setGrp == GRP_LAST) && (setOff == OFF_LAST);
    strb.addrWr    = rxValid && (rxCnt < ADDR_N);
    strb.addrIdx   = rxCnt[BYTE_W-1:0];
    strb.decide    = rxValid && (rxCnt == ADDR_LAST);
    strb.frameEnd  = rxValid && rxLast;
    strb.lenOk     = rxCnt >= LEN_LAST;
  end
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  daf_strobe_t strb,
  input  logic [7:0]  setupByte,
  input  logic [7:0]  rxByte,
  input  logic        modePromisc,
  input  logic        modeRecvAll,
  input  logic        modePassMcast,
  input  logic        modeInverse,
  output logic        decValid,
  output logic        addrAccept,
  output logic        flagFiltFail,
  output logic        flagMcast,
  output logic        frameDone,
  output logic        frameAccept
);
  mac_t stage [ENTRIES];
  mac_t tbl   [ENTRIES];
  mac_t addrReg;
  mac_t curAddr;
  logic [ENTRIES-1:0] hit;
  logic anyHit, isBcast, vAcc, vFF, vMC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) stage[e] <= '0;
    end else if (strb.stageWr) begin
      stage[strb.stageEnt][strb.stageByte] <= setupByte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addrReg <= '0;
    else if (strb.addrWr) addrReg[strb.addrIdx] <= rxByte;
  end

  // the sixth byte bypasses the register so the verdict registers on its edge
  always_comb begin
    curAddr                 = addrReg;
    curAddr[ADDR_BYTES-1]   = rxByte;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tbl[e] <= '0;
      else if (strb.commit) tbl[e] <= stage[e];
    end
    assign hit[e] = (tbl[e] == curAddr);
  end

  assign anyHit  = |hit;
  assign isBcast = &curAddr;

  always_comb begin
    vAcc = 1'b0;
    vFF  = 1'b0;
    vMC  = 1'b0;
    if (isBcast) begin
      vAcc = 1'b1;
    end else if (modePromisc || modeRecvAll) begin
      vAcc = 1'b1;
      vFF  = 1'b1;
    end else if (modePassMcast && curAddr[0][0]) begin
      vAcc = 1'b1;
      vMC  = 1'b1;
    end else begin
      vAcc = anyHit ^ modeInverse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decValid     <= 1'b0;
      addrAccept   <= 1'b0;
      flagFiltFail <= 1'b0;
      flagMcast    <= 1'b0;
      frameDone    <= 1'b0;
      frameAccept  <= 1'b0;
    end else begin
      decValid    <= strb.decide;
      frameDone   <= strb.frameEnd;
      frameAccept <= strb.frameEnd && strb.lenOk && addrAccept;
      if (strb.decide) begin
        addrAccept   <= vAcc;
        flagFiltFail <= vFF;
        flagMcast    <= vMC;
      end
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       modePromisc,
  input  logic       modeRecvAll,
  input  logic       modePassMcast,
  input  logic       modeInverse,
  input  logic       setupValid,
  input  logic [7:0] setupByte,
  input  logic       setupLast,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       rxLast,
  output logic       decValid,
  output logic       addrAccept,
  output logic       flagFiltFail,
  output logic       flagMcast,
  output logic       frameDone,
  output logic       frameAccept
);
  daf_strobe_t strb;

  daf_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .setupValid(setupValid), .setupLast(setupLast),
    .rxValid(rxValid), .rxLast(rxLast),
    .strb(strb)
  );

  daf_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .setupByte(setupByte), .rxByte(rxByte),
    .modePromisc(modePromisc), .modeRecvAll(modeRecvAll),
    .modePassMcast(modePassMcast), .modeInverse(modeInverse),
    .decValid(decValid), .addrAccept(addrAccept),
    .flagFiltFail(flagFiltFail), .flagMcast(flagMcast),
    .frameDone(frameDone), .frameAccept(frameAccept)
  );
endmodule

// File: rtl/daf_chk.sv
module daf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       modePromisc,
  input logic       modeRecvAll,
  input logic       rxValid,
  input logic [7:0] rxByte,
  input logic       rxLast,
  input logic       decValid,
  input logic       addrAccept,
  input logic       flagFiltFail,
  input logic       flagMcast,
  input logic       frameDone,
  input logic       frameAccept
);
  logic [4:0] seenCnt;
  logic       allOnes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenCnt <= '0;
      allOnes <= 1'b0;
    end else if (rxValid) begin
      if (rxLast)              seenCnt <= '0;
      else if (seenCnt != '1)  seenCnt <= seenCnt + 1'b1;
      if (seenCnt == 5'd0)     allOnes <= (rxByte == 8'hFF);
      else if (seenCnt < 5'd6) allOnes <= allOnes && (rxByte == 8'hFF);
    end
  end

  // R2
  dec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decValid |-> ($past(rxValid) && $past(seenCnt) == 5'd5));

  // R9
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameAccept |-> (frameDone && $past(seenCnt) >= 5'd13));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flagFiltFail && flagMcast));

  // R7
  flag_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagFiltFail || flagMcast) |-> addrAccept);

  // R5
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && allOnes) |-> (addrAccept && !flagFiltFail && !flagMcast));

  // R6
  promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decValid && !allOnes && $past(modePromisc || modeRecvAll)) |-> (addrAccept && flagFiltFail));
endmodule

bind dest_addr_filter daf_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .modePromisc(modePromisc), .modeRecvAll(modeRecvAll),
  .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast),
  .decValid(decValid), .addrAccept(addrAccept),
  .flagFiltFail(flagFiltFail), .flagMcast(flagMcast),
  .frameDone(frameDone), .frameAccept(frameAccept)
);

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mPr = 0, mRa = 0, mPm = 0, mIv = 0;
  logic setupValid = 0, setupLast = 0, rxValid = 0, rxLast = 0;
  logic [7:0] setupByte = '0, rxByte = '0;
  logic decValid, addrAccept, flagFiltFail, flagMcast, frameDone, frameAccept;

  always #4 clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .modePromisc(mPr), .modeRecvAll(mRa), .modePassMcast(mPm), .modeInverse(mIv),
    .setupValid(setupValid), .setupByte(setupByte), .setupLast(setupLast),
    .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast),
    .decValid(decValid), .addrAccept(addrAccept),
    .flagFiltFail(flagFiltFail), .flagMcast(flagMcast),
    .frameDone(frameDone), .frameAccept(frameAccept)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mdl [16][6];
  logic [7:0] fa [6];
  logic capDec, capAcc, capFF, capMC, capDone, capFAcc, capEarly;
  logic expAcc, expFF, expMC;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] entryByte(input int seed, input int g, input int k);
    logic [7:0] b;
    b = 8'(seed * 37 + g * 13 + k * 71 + 3);
    if (k == 0) b[0] = 1'b0;
    return b;
  endfunction

  task automatic sendSetup(input int len, input int seed);
    for (int p = 0; p < len; p++) begin
      int g, o;
      g = p / 12;
      o = p % 12;
      setupValid = 1'b1;
      setupLast  = (p == len - 1);
      setupByte  = (o % 4 < 2 && g < 16) ? entryByte(seed, g, (o / 4) * 2 + o % 2) : 8'hEE;
      @(negedge clk);
    end
    setupValid = 1'b0;
    setupLast  = 1'b0;
    @(negedge clk);
    if (len == 192)
      for (int g = 0; g < 16; g++)
        for (int k = 0; k < 6; k++) mdl[g][k] = entryByte(seed, g, k);
  endtask

  task automatic sendFrame(input int len);
    capDec = 0; capAcc = 0; capFF = 0; capMC = 0; capEarly = 0;
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1;
      rxLast  = (i == len - 1);
      rxByte  = (i < 6) ? fa[i] : 8'(8'h11 + i);
      @(negedge clk);
      if (i == 4) capEarly = decValid;
      if (i == 5) begin
        capDec = decValid; capAcc = addrAccept; capFF = flagFiltFail; capMC = flagMcast;
      end
    end
    capDone = frameDone;
    capFAcc = frameAccept;
    rxValid = 1'b0;
    rxLast  = 1'b0;
    @(negedge clk);
  endtask

  task automatic model();
    logic hit, bc;
    hit = 0;
    bc = 1;
    for (int g = 0; g < 16; g++) begin
      logic same;
      same = 1;
      for (int k = 0; k < 6; k++) if (mdl[g][k] != fa[k]) same = 0;
      if (same) hit = 1;
    end
    for (int k = 0; k < 6; k++) if (fa[k] != 8'hFF) bc = 0;
    expFF = 0; expMC = 0;
    if (bc) expAcc = 1;
    else if (mPr || mRa) begin expAcc = 1; expFF = 1; end
    else if (mPm && fa[0][0]) begin expAcc = 1; expMC = 1; end
    else expAcc = hit ^ mIv;
  endtask

  task automatic setAddr(input logic [7:0] b0, b1, b2, b3, b4, b5);
    fa[0] = b0; fa[1] = b1; fa[2] = b2; fa[3] = b3; fa[4] = b4; fa[5] = b5;
  endtask

  task automatic useEntry(input int g);
    for (int k = 0; k < 6; k++) fa[k] = mdl[g][k];
  endtask

  task automatic frameCheck(input string req, input int len);
    model();
    sendFrame(len);
    check({req, " early"}, capEarly, 0);
    check({req, " decValid"}, capDec, 1);
    check({req, " accept"}, capAcc, expAcc);
    check({req, " filtfail"}, capFF, expFF);
    check({req, " mcast"}, capMC, expMC);
    check({req, " frameDone"}, capDone, 1);
    check({req, " frameAccept"}, capFAcc, (len >= 14) && expAcc);
  endtask

  initial begin
    for (int g = 0; g < 16; g++) for (int k = 0; k < 6; k++) mdl[g][k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {decValid, addrAccept, flagFiltFail, flagMcast, frameDone, frameAccept}, 0);
    setAddr(8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    frameCheck("R1 unicast after reset", 14);
    check("R1 unicast rejected", capAcc, 0);
    setAddr(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    frameCheck("R1 zero address", 14);
    check("R1 zero matches", capAcc, 1);

    // R3 R4 R10: load and sweep every entry
    sendSetup(192, 1);
    for (int g = 0; g < 16; g++) begin
      useEntry(g);
      frameCheck("R10 R4 entry match", 14);
      check("R10 entry accepted", capAcc, 1);
      fa[g % 6] = fa[g % 6] ^ 8'h40;
      frameCheck("R8 near miss", 14);
      check("R8 near miss rejected", capAcc, 0);
    end

    // R3 wrong lengths leave table unchanged
    sendSetup(191, 2);
    useEntry(7);
    frameCheck("R3 after 191", 14);
    check("R3 191 ignored", capAcc, 1);
    sendSetup(193, 3);
    useEntry(12);
    frameCheck("R3 after 193", 14);
    check("R3 193 ignored", capAcc, 1);
    for (int k = 0; k < 6; k++) fa[k] = entryByte(3, 4, k);
    frameCheck("R3 seed3 absent", 14);
    check("R3 seed3 not loaded", capAcc, 0);

    // R5..R8 sweep of modes against four address classes
    for (int m = 0; m < 16; m++) begin
      mPr = m[0]; mRa = m[1]; mPm = m[2]; mIv = m[3];
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        case (c)
          0: useEntry(m);
          1: setAddr(8'h0A, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
          2: setAddr(8'h0B, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
          default: setAddr(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        endcase
        frameCheck(c == 3 ? "R5 bcast sweep" : (m[1:0] != 0 ? "R6 promisc sweep" :
                   (m[2] ? "R7 mcast sweep" : "R8 match sweep")), 14);
      end
    end

    // R9 length limits
    mPr = 0; mRa = 0; mPm = 0; mIv = 0;
    useEntry(3);
    frameCheck("R9 len13", 13);
    check("R9 13 rejected", capFAcc, 0);
    frameCheck("R9 len14", 14);
    check("R9 14 accepted", capFAcc, 1);
    frameCheck("R9 len6", 6);
    sendFrame(5);
    check("R9 len5 no decValid", capDec, 0);
    check("R9 len5 done", capDone, 1);
    check("R9 len5 rejected", capFAcc, 0);

    // R2 decValid is a single-cycle pulse
    check("R2 pulse gone", decValid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule